// File: doc/BRIEF.md
# Operand Specifier Length Decoder

This block takes one variable-length operand specifier at a time from a byte-wide valid/ready stream and turns it into a single decoded record. The first byte of each specifier is the mode byte. Its upper nibble selects one of sixteen addressing modes and its lower nibble names a general register. Depending on the mode, the register and the operand data length, zero or more extension bytes follow. The decoder absorbs these bytes and assembles them into a 32-bit displacement, literal or address. It then presents the mode, register, total byte count and value, together with flags that mark the deferred, immediate, absolute and index forms.

The operand data length comes from opcode decode upstream. It is a side input, `in_oplen`, encoded 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes, and it is sampled together with the mode byte. The block computes no addresses and touches no memory or register file. Register 15 is treated as the program counter.

The control is a three-state machine:

- `ST_MODE` waits for a mode byte.
- `ST_EXT` collects extension bytes.
- `ST_EMIT` holds the record until the consumer takes it.

The transitions are:

- `ST_MODE` goes to `ST_EMIT` when the accepted mode byte needs no extension bytes or is in error.
- `ST_MODE` goes to `ST_EXT` otherwise.
- `ST_EXT` goes to `ST_EMIT` when the last extension byte is accepted.
- `ST_EMIT` goes to `ST_MODE` when `out_ready` is high.

Top module: `opspec_decoder`

## Requirements
- R1: For every record, `out_mode` equals bits 7:4 and `out_reg` equals bits 3:0 of the mode byte that opened it.
- R2: Modes 0 to 3 are short literals: length 1, value equals bits 5:0 of the mode byte (0 to 63), and all flags are low.
- R3: Mode 4 sets `out_index` with length 1. Modes 5, 6 and 7, and modes 8 and 9 with a register other than 15, have length 1. All of these give value 0 and no other flags.
- R4: Modes 0xA/0xB take one extension byte (length 2), 0xC/0xD take two (length 3), and 0xE/0xF take four (length 5). `out_deferred` is high exactly for 0xB, 0xD and 0xF.
- R5: Extension bytes are little-endian, with the first received byte holding bit 0. Displacements of modes 0xA to 0xF are sign-extended to 32 bits.
- R6: Mode 8 with register 15 is immediate. It sets `out_immediate`, takes as many extension bytes as the operand length, and gives a zero-extended value.
- R7: Mode 9 with register 15 is absolute. It sets `out_absolute`, takes four extension bytes (length 5) and gives the raw 32-bit address.
- R8: If the total length exceeds `MAX_LEN` (default 6), `out_error` is high and `out_len` reports the computed length. The value is 0 and no extension bytes are consumed, so the next byte accepted is a new mode byte.
- R9: While `out_valid` is high, `in_ready` is low. While `out_valid` is high and `out_ready` is low, the record holds stable.
- R10: After reset, `out_valid` is low and `in_ready` is high.
- R11: Idle cycles (`in_valid` low) between extension bytes do not change the decoded record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Stream byte valid |
| in_byte | input | 8 | Stream byte |
| in_oplen | input | 2 | Operand length code, sampled with the mode byte |
| in_ready | output | 1 | Decoder accepts a byte |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_mode | output | 4 | Addressing mode |
| out_reg | output | 4 | Register number |
| out_len | output | 4 | Total specifier length in bytes |
| out_value | output | 32 | Literal, displacement or address |
| out_deferred | output | 1 | Deferred displacement form |
| out_immediate | output | 1 | Immediate form |
| out_absolute | output | 1 | Absolute form |
| out_index | output | 1 | Index prefix |
| out_error | output | 1 | Length exceeds the maximum |

## Verification
The hardest situation to reach is an error record followed directly by a normal specifier. The byte after an oversized immediate must be taken as a fresh mode byte, not as part of the rejected literal. The stimulus sends an 8-byte immediate and then a different specifier straight away. It also holds `out_ready` low for random stretches so that the error record stalls with the next mode byte already waiting. Random mode bytes with random operand lengths, and gaps inserted between extension bytes, cover the remaining length and sign-extension combinations.

// File: rtl/opspec_pkg.sv
package opspec_pkg;

    localparam int LEN_W = 4;
    localparam int VAL_W = 32;
    localparam logic [3:0] PC_REG = 4'hF;

    typedef enum logic [1:0] {
        ST_MODE,
        ST_EXT,
        ST_EMIT
    } dec_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] ext_cnt;
        logic [LEN_W-1:0] total_len;
        logic             is_disp;
        logic             short_lit;
        logic             deferred;
        logic             immediate;
        logic             absolute;
        logic             index;
        logic             error;
    } spec_class_t;

endpackage

// File: rtl/opspec_classify.sv
module opspec_classify
    import opspec_pkg::*;
#(
    parameter int MAX_LEN = 6
) (
    input  logic [7:0]  mode_byte,
    input  logic [1:0]  oplen,
    output spec_class_t cls
);

    logic [3:0] mode;
    logic [3:0] rnum;

    assign mode = mode_byte[7:4];
    assign rnum = mode_byte[3:0];

    always_comb begin
        cls = '0;
        unique case (mode)
            4'h0, 4'h1, 4'h2, 4'h3: cls.short_lit = 1'b1;
            4'h4:                   cls.index = 1'b1;
            4'h5, 4'h6, 4'h7:       cls.ext_cnt = '0;
            4'h8: begin
                if (rnum == PC_REG) begin
                    cls.immediate = 1'b1;
                    cls.ext_cnt   = LEN_W'(1) << oplen;
                end
            end
            4'h9: begin
                if (rnum == PC_REG) begin
                    cls.absolute = 1'b1;
                    cls.ext_cnt  = LEN_W'(4);
                end
            end
            4'hA, 4'hB: begin
                cls.is_disp = 1'b1;
                cls.ext_cnt = LEN_W'(1);
            end
            4'hC, 4'hD: begin
                cls.is_disp = 1'b1;
                cls.ext_cnt = LEN_W'(2);
            end
            default: begin
                cls.is_disp = 1'b1;
                cls.ext_cnt = LEN_W'(4);
            end
        endcase
        cls.deferred  = cls.is_disp & mode[0];
        cls.total_len = cls.ext_cnt + LEN_W'(1);
        cls.error     = (int'(cls.total_len) > MAX_LEN);
    end

endmodule

// File: rtl/opspec_fsm.sv
module opspec_fsm
    import opspec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             out_ready,
    input  logic [LEN_W-1:0] mode_ext_cnt,
    input  logic             mode_error,
    output logic             in_ready,
    output logic             out_valid,
    output logic             take_mode,
    output logic             take_ext,
    output logic [LEN_W-1:0] ext_idx
);

    dec_state_e       state_q, state_d;
    logic [LEN_W-1:0] remain_q;
    logic [LEN_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_MODE;
            remain_q <= '0;
            idx_q    <= '0;
        end else begin
            state_q <= state_d;
            if (take_mode) begin
                remain_q <= mode_ext_cnt;
                idx_q    <= '0;
            end else if (take_ext) begin
                remain_q <= remain_q - LEN_W'(1);
                idx_q    <= idx_q + LEN_W'(1);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MODE: begin
                if (in_valid) begin
                    if (mode_error || mode_ext_cnt == '0) state_d = ST_EMIT;
                    else                                  state_d = ST_EXT;
                end
            end
            ST_EXT: begin
                if (in_valid && remain_q == LEN_W'(1)) state_d = ST_EMIT;
            end
            ST_EMIT: begin
                if (out_ready) state_d = ST_MODE;
            end
            default: state_d = ST_MODE;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_MODE: in_ready  = 1'b1;
            ST_EXT:  in_ready  = 1'b1;
            ST_EMIT: out_valid = 1'b1;
            default: ;
        endcase
        take_mode = (state_q == ST_MODE) && in_valid;
        take_ext  = (state_q == ST_EXT) && in_valid;
        ext_idx   = idx_q;
    end

endmodule

// File: rtl/opspec_assemble.sv
module opspec_assemble
    import opspec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_mode,
    input  logic             take_ext,
    input  logic [LEN_W-1:0] ext_idx,
    input  logic [7:0]       in_byte,
    input  spec_class_t      cls,
    output logic [3:0]       rec_mode,
    output logic [3:0]       rec_reg,
    output logic [LEN_W-1:0] rec_len,
    output logic [VAL_W-1:0] rec_value,
    output logic             rec_deferred,
    output logic             rec_immediate,
    output logic             rec_absolute,
    output logic             rec_index,
    output logic             rec_error
);

    localparam int NBYTES = VAL_W / 8;

    spec_class_t      cls_q;
    logic [3:0]       mode_q;
    logic [3:0]       reg_q;
    logic [VAL_W-1:0] raw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_q  <= '0;
            mode_q <= '0;
            reg_q  <= '0;
            raw_q  <= '0;
        end else if (take_mode) begin
            cls_q  <= cls;
            mode_q <= in_byte[7:4];
            reg_q  <= in_byte[3:0];
            raw_q  <= cls.short_lit ? VAL_W'(in_byte[5:0]) : '0;
        end else if (take_ext) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (ext_idx == LEN_W'(b)) raw_q[b*8 +: 8] <= in_byte;
            end
        end
    end

    always_comb begin
        rec_value = raw_q;
        if (cls_q.is_disp) begin
            unique case (cls_q.ext_cnt)
                LEN_W'(1): rec_value = {{(VAL_W-8){raw_q[7]}}, raw_q[7:0]};
                LEN_W'(2): rec_value = {{(VAL_W-16){raw_q[15]}}, raw_q[15:0]};
                default:   rec_value = raw_q;
            endcase
        end
    end

    assign rec_mode      = mode_q;
    assign rec_reg       = reg_q;
    assign rec_len       = cls_q.total_len;
    assign rec_deferred  = cls_q.deferred;
    assign rec_immediate = cls_q.immediate;
    assign rec_absolute  = cls_q.absolute;
    assign rec_index     = cls_q.index;
    assign rec_error     = cls_q.error;

endmodule

// File: rtl/opspec_decoder.sv
module opspec_decoder
    import opspec_pkg::*;
#(
    parameter int MAX_LEN = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    input  logic [1:0]  in_oplen,
    output logic        in_ready,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [3:0]  out_mode,
    output logic [3:0]  out_reg,
    output logic [3:0]  out_len,
    output logic [31:0] out_value,
    output logic        out_deferred,
    output logic        out_immediate,
    output logic        out_absolute,
    output logic        out_index,
    output logic        out_error
);

    spec_class_t      cls;
    logic             take_mode;
    logic             take_ext;
    logic [LEN_W-1:0] ext_idx;

    opspec_classify #(.MAX_LEN(MAX_LEN)) i_classify (
        .mode_byte (in_byte),
        .oplen     (in_oplen),
        .cls       (cls)
    );

    opspec_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .out_ready    (out_ready),
        .mode_ext_cnt (cls.ext_cnt),
        .mode_error   (cls.error),
        .in_ready     (in_ready),
        .out_valid    (out_valid),
        .take_mode    (take_mode),
        .take_ext     (take_ext),
        .ext_idx      (ext_idx)
    );

    opspec_assemble i_assemble (
        .clk           (clk),
        .rst_n         (rst_n),
        .take_mode     (take_mode),
        .take_ext      (take_ext),
        .ext_idx       (ext_idx),
        .in_byte       (in_byte),
        .cls           (cls),
        .rec_mode      (out_mode),
        .rec_reg       (out_reg),
        .rec_len       (out_len),
        .rec_value     (out_value),
        .rec_deferred  (out_deferred),
        .rec_immediate (out_immediate),
        .rec_absolute  (out_absolute),
        .rec_index     (out_index),
        .rec_error     (out_error)
    );

endmodule

// File: rtl/opspec_decoder_chk.sv
module opspec_decoder_chk #(
    parameter int MAX_LEN = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [3:0]  out_mode,
    input logic [3:0]  out_reg,
    input logic [3:0]  out_len,
    input logic [31:0] out_value,
    input logic        out_deferred,
    input logic        out_immediate,
    input logic        out_absolute,
    input logic        out_error
);

    // R9
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_value)
            && $stable(out_len) && $stable(out_mode) && $stable(out_reg)));

    // R8
    err_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_error) |-> (int'(out_len) > MAX_LEN && out_value == 32'd0));

    // R4
    deferred_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_deferred) |-> (out_mode[0] && out_mode >= 4'hB));

    // R6
    imm_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_immediate) |-> (out_mode == 4'h8 && out_reg == 4'hF));

    // R7
    abs_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_absolute) |-> (out_len == 4'd5));

    // R2
    short_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode < 4'h4) |-> (out_len == 4'd1 && out_value < 32'd64));

endmodule

bind opspec_decoder opspec_decoder_chk #(.MAX_LEN(MAX_LEN)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_mode      (out_mode),
    .out_reg       (out_reg),
    .out_len       (out_len),
    .out_value     (out_value),
    .out_deferred  (out_deferred),
    .out_immediate (out_immediate),
    .out_absolute  (out_absolute),
    .out_error     (out_error)
);

// File: tb/test_opspec_decoder.sv
`timescale 1ns/1ps
module test_opspec_decoder;

    typedef struct packed {
        logic [3:0]  mode;
        logic [3:0]  rnum;
        logic [3:0]  len;
        logic [31:0] value;
        logic        def;
        logic        imm;
        logic        abso;
        logic        idx;
        logic        err;
    } rec_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic [1:0]  in_oplen = '0;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [3:0]  out_mode, out_reg, out_len;
    logic [31:0] out_value;
    logic        out_deferred, out_immediate, out_absolute, out_index, out_error;

    int checks = 0;
    int fails = 0;
    rec_t q[$];
    bit done = 1'b0;
    int ready_mode = 0;

    always #4 clk = ~clk;

    opspec_decoder i_opspec_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_oplen(in_oplen), .in_ready(in_ready), .out_valid(out_valid),
        .out_ready(out_ready), .out_mode(out_mode), .out_reg(out_reg),
        .out_len(out_len), .out_value(out_value), .out_deferred(out_deferred),
        .out_immediate(out_immediate), .out_absolute(out_absolute),
        .out_index(out_index), .out_error(out_error)
    );

    function automatic rec_t expect_of(logic [7:0] mb, logic [1:0] ol, logic [7:0] ex [8]);
        rec_t e;
        int n;
        logic [31:0] raw;
        e = '0;
        e.mode = mb[7:4];
        e.rnum = mb[3:0];
        n = 0;
        if (mb[7:4] < 4'h4) e.value = {26'd0, mb[5:0]};          // R2
        else if (mb[7:4] == 4'h4) e.idx = 1'b1;                  // R3
        else if (mb[7:4] == 4'h8 && mb[3:0] == 4'hF) begin e.imm = 1'b1; n = 1 << ol; end // R6
        else if (mb[7:4] == 4'h9 && mb[3:0] == 4'hF) begin e.abso = 1'b1; n = 4; end      // R7
        else if (mb[7:4] >= 4'hA) begin                          // R4
            n = (mb[7:4] <= 4'hB) ? 1 : (mb[7:4] <= 4'hD) ? 2 : 4;
            e.def = mb[4];
        end
        e.len = 4'(n + 1);
        if (n + 1 > 6) e.err = 1'b1;                             // R8
        else if (n > 0) begin                                    // R5
            raw = '0;
            for (int b = 0; b < n && b < 4; b++) raw[b*8 +: 8] = ex[b];
            if (mb[7:4] >= 4'hA && n == 1) raw = {{24{raw[7]}}, raw[7:0]};
            else if (mb[7:4] >= 4'hA && n == 2) raw = {{16{raw[15]}}, raw[15:0]};
            e.value = raw;
        end
        return e;
    endfunction

    task automatic put(input logic [7:0] b, input logic [1:0] ol, input int gap);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        in_oplen = ol;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic send(input logic [7:0] mb, input logic [1:0] ol, input logic [7:0] ex [8], input int gap);
        rec_t e;
        e = expect_of(mb, ol, ex);
        q.push_back(e);
        put(mb, ol, 0);
        if (!e.err) begin
            for (int b = 0; b < int'(e.len) - 1; b++) put(ex[b], 2'd0, gap);  // R11 via gap
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // monitor / scoreboard
    rec_t prev;
    bit   hold_prev = 1'b0;
    always @(negedge clk) begin
        rec_t act;
        rec_t e;
        if (rst_n) begin
            act = '{out_mode, out_reg, out_len, out_value, out_deferred,
                    out_immediate, out_absolute, out_index, out_error};
            if (hold_prev) begin
                checks++;
                if (!out_valid || act != prev) begin
                    fails++;
                    $display("FAIL R9 hold: actual %h expected %h", act, prev);
                end
            end
            if (out_valid) begin
                checks++;
                if (in_ready) begin
                    fails++;
                    $display("FAIL R9 in_ready: actual 1 expected 0");
                end
            end
            out_ready = (ready_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
            if (out_valid && out_ready) begin
                checks++;
                if (q.size() == 0) begin
                    fails++;
                    $display("FAIL R1 unexpected record: actual %h expected none", act);
                end else begin
                    e = q.pop_front();
                    if (act != e) begin
                        fails++;
                        $display("FAIL R1-R8 record: actual %h expected %h", act, e);
                    end
                end
            end
            hold_prev = out_valid && !out_ready;
            prev = act;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] ex [8];
        for (int i = 0; i < 8; i++) ex[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;                                                // R10
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            fails++;
            $display("FAIL R10 reset: actual v=%b r=%b expected v=0 r=1", out_valid, in_ready);
        end
        // R1 R2 short literals
        send(8'h00, 0, ex, 0);
        send(8'h3F, 0, ex, 0);
        send(8'h2A, 1, ex, 0);
        // R3 no-extension modes
        send(8'h45, 0, ex, 0);
        send(8'h5A, 0, ex, 0);
        send(8'h6F, 0, ex, 0);
        send(8'h7B, 0, ex, 0);
        send(8'h83, 2, ex, 0);
        send(8'h93, 3, ex, 0);
        // R4 R5 displacements with sign extension
        ex[0] = 8'h80; send(8'hA1, 0, ex, 0);
        ex[0] = 8'h7F; send(8'hB2, 0, ex, 0);
        ex[0] = 8'h34; ex[1] = 8'h92; send(8'hC3, 0, ex, 0);
        ex[0] = 8'hFF; ex[1] = 8'h7F; send(8'hDE, 0, ex, 1);
        ex[0] = 8'h78; ex[1] = 8'h56; ex[2] = 8'h34; ex[3] = 8'h92; send(8'hE5, 0, ex, 0);
        send(8'hFF, 0, ex, 2);                                   // R11 gaps
        // R6 immediates
        ex[0] = 8'hC8; send(8'h8F, 0, ex, 0);
        ex[0] = 8'h01; ex[1] = 8'hF2; send(8'h8F, 1, ex, 0);
        ex[0] = 8'hEF; ex[1] = 8'hBE; ex[2] = 8'hAD; ex[3] = 8'hDE; send(8'h8F, 2, ex, 3);
        // R7 absolute
        send(8'h9F, 1, ex, 0);
        // R8 oversized immediate followed directly by a new specifier
        send(8'h8F, 3, ex, 0);
        ex[0] = 8'h81; send(8'hA7, 0, ex, 0);
        send(8'h8F, 3, ex, 0);
        send(8'h15, 0, ex, 0);
        // random traffic with a stalling consumer
        ready_mode = 1;
        for (int k = 0; k < 80; k++) begin
            logic [7:0] mb;
            mb = 8'($urandom);
            if (k % 5 == 0) mb[3:0] = 4'hF;
            for (int i = 0; i < 8; i++) ex[i] = 8'($urandom);
            send(mb, 2'($urandom), ex, int'($urandom % 3));
        end
        repeat (40) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R9 drain: actual %0d pending expected 0", q.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule